// File: doc/BRIEF.md
# Breadth-First Graph Traversal Engine

This engine walks a directed graph outward from one chosen vertex, one hop ring at a time. The graph sits in two on-chip memories that the engine reads. The first is a row-start table indexed by vertex: entry `u` holds the position of the first out-edge of `u`, and entry `u+1` marks where that list ends. The second is an edge-target table that holds the destination vertex of each edge. Both memories are external to the engine and return data one cycle after the address is presented.

A one-cycle `start` pulse carries the source vertex. The engine then runs a FIFO work list through four steps: take the vertex at the head of the list, read its row bounds and edge targets, drop targets that have already been seen, and record results for new vertices while appending them to the list. Each reached vertex gets four results: its hop level, its parent, its discovery stamp and its finish stamp. Both stamps come from one shared counter. Levels are derived from frontier-size counters rather than stored in the work list. A one-cycle `done` pulse marks the moment the work list runs empty. A combinational read port then returns the four results for any vertex.

Top module: `bfs_engine`

## Requirements
- R1: After reset, `busy` and `done` are low, and all four read-port fields return the sentinel (all ones of RW bits) for every vertex.
- R2: After a run, the source vertex reads level 0, parent equal to its own id, and discovery stamp 0.
- R3: The out-neighbours of `u` are the edge-target entries at positions from row-start[u] up to, but not including, row-start[u+1]. Vertices are expanded in FIFO order, and the neighbours of each vertex are examined in ascending position.
- R4: The stamp counter is 0 at start and is not advanced for the source. A newly found vertex takes the current value, and the counter then adds 1. When the scan of a popped vertex ends, that vertex's finish stamp takes the current value, and the counter then adds 1.
- R5: A vertex found while the engine expands level-k vertices gets level k+1. The level advances when the number of pops in the current ring reaches the ring size, which is 1 for the source ring. The next ring's size is the number of vertices found during the current ring.
- R6: The parent of a reached vertex is the popped vertex whose scan found it first.
- R7: A target that appears more than once in one list, or a self-loop, is recorded and queued at most once. A later sighting leaves its results unchanged.
- R8: Every vertex not reachable from the source reads the sentinel in all four fields.
- R9: `busy` is high from the cycle after an accepted `start` until `done`. `done` is high for exactly one cycle. A `start` pulse while `busy` is high is ignored.
- R10: A new run clears all results of the previous run before it begins.
- R11: The work list holds 2**VW entries and never overflows, even when one vertex discovers every other vertex.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a traversal |
| src | input | VW | Source vertex id, sampled together with `start` |
| busy | output | 1 | High while a traversal is running |
| done | output | 1 | One-cycle pulse when the work list is empty |
| off_addr | output | VW+1 | Row-start memory address |
| off_data | input | EW+1 | Row-start memory data, one cycle after the address |
| col_addr | output | EW | Edge-target memory address |
| col_data | input | VW | Edge-target memory data, one cycle after the address |
| rd_addr | input | VW | Result read address |
| rd_level | output | RW | Hop level of `rd_addr`, or the sentinel |
| rd_parent | output | RW | Parent of `rd_addr`, or the sentinel |
| rd_disc | output | RW | Discovery stamp of `rd_addr`, or the sentinel |
| rd_fin | output | RW | Finish stamp of `rd_addr`, or the sentinel |

## Verification
Two things can happen in the same cycle: the finish stamp of the last vertex in a ring, and the ring rollover that advances the level counter. Both read the shared counters at that edge, and the next vertex's level and stamps depend on both. A chain graph causes this on every pop, because every ring holds one vertex. A binary tree and a graph full of duplicate edges and self-loops cause it at uneven intervals. The bench judges each run against a software traversal that follows the stamping and ring rules. It does this for every source vertex, and it compares all four fields of every vertex.

// File: rtl/bfs_pkg.sv
package bfs_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_POP,
      ST_ROW_LO,
      ST_ROW_HI,
      ST_ROW_END,
      ST_SCAN,
      ST_FILT,
      ST_FIN
   } bfs_state_t;
endpackage

// File: rtl/bfs_queue.sv
module bfs_queue #(
   parameter int VW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [VW-1:0] din,
   input  logic          pop,
   output logic [VW-1:0] head,
   output logic          empty,
   output logic          full
);
   localparam int DEPTH = 1 << VW;

   logic [VW-1:0] store_q [DEPTH];
   logic [VW-1:0] wp_q, rp_q;
   logic [VW:0]   cnt_q;

   assign empty = (cnt_q == '0);
   assign full  = (cnt_q == (VW+1)'(DEPTH));
   assign head  = store_q[rp_q];

   always_ff @(posedge clk) begin
      if (push) store_q[wp_q] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push) wp_q <= wp_q + 1'b1;
         if (pop)  rp_q <= rp_q + 1'b1;
         case ({push, pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   // R11
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (!full || pop));

   // R11
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/bfs_result_store.sv
module bfs_result_store #(
   parameter int VW     = 4,
   parameter int RW     = 6,
   parameter bit RD_REG = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          disc_we,
   input  logic [VW-1:0] disc_v,
   input  logic [RW-1:0] disc_t,
   input  logic [RW-1:0] disc_lvl,
   input  logic [RW-1:0] disc_par,
   input  logic          fin_we,
   input  logic [VW-1:0] fin_v,
   input  logic [RW-1:0] fin_t,
   input  logic [VW-1:0] probe_v,
   output logic          probe_seen,
   input  logic [VW-1:0] rd_addr,
   output logic [RW-1:0] rd_level,
   output logic [RW-1:0] rd_parent,
   output logic [RW-1:0] rd_disc,
   output logic [RW-1:0] rd_fin
);
   localparam int NV = 1 << VW;
   localparam logic [RW-1:0] SENT = '1;

   logic [NV-1:0] seen_q;
   logic [RW-1:0] lvl_m [NV];
   logic [RW-1:0] par_m [NV];
   logic [RW-1:0] dsc_m [NV];
   logic [RW-1:0] fin_m [NV];

   assign probe_seen = seen_q[probe_v];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q <= '0;
      end else begin
         if (clr)     seen_q <= '0;
         if (disc_we) seen_q[disc_v] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (disc_we) begin
         lvl_m[disc_v] <= disc_lvl;
         par_m[disc_v] <= disc_par;
         dsc_m[disc_v] <= disc_t;
      end
      if (fin_we) fin_m[fin_v] <= fin_t;
   end

   logic [4*RW-1:0] rd_comb;
   assign rd_comb = seen_q[rd_addr] ?
      {lvl_m[rd_addr], par_m[rd_addr], dsc_m[rd_addr], fin_m[rd_addr]} : {4{SENT}};

   generate
      if (RD_REG) begin : g_rd_reg
         logic [4*RW-1:0] rd_q;
         always_ff @(posedge clk) rd_q <= rd_comb;
         assign {rd_level, rd_parent, rd_disc, rd_fin} = rd_q;
      end else begin : g_rd_comb
         assign {rd_level, rd_parent, rd_disc, rd_fin} = rd_comb;
      end
   endgenerate

   // R7
   single_discovery_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (disc_we && !clr) |-> !seen_q[disc_v]);

   // R4
   finish_after_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fin_we |-> seen_q[fin_v]);
endmodule

// File: rtl/bfs_engine.sv
module bfs_engine
   import bfs_pkg::*;
#(
   parameter int VW     = 4,
   parameter int EW     = 6,
   parameter int RW     = 6,
   parameter bit RD_REG = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [VW-1:0] src,
   output logic          busy,
   output logic          done,
   output logic [VW:0]   off_addr,
   input  logic [EW:0]   off_data,
   output logic [EW-1:0] col_addr,
   input  logic [VW-1:0] col_data,
   input  logic [VW-1:0] rd_addr,
   output logic [RW-1:0] rd_level,
   output logic [RW-1:0] rd_parent,
   output logic [RW-1:0] rd_disc,
   output logic [RW-1:0] rd_fin
);
   localparam int NV = 1 << VW;

   generate
      if (RW < VW + 2) begin : g_bad_rw
         $error("RW must reach VW+2 so stamps never meet the sentinel");
      end
      if (EW < 1 || VW < 1) begin : g_bad_w
         $error("VW and EW must be at least 1");
      end
   endgenerate

   bfs_state_t    state_q;
   logic [VW-1:0] u_q;
   logic [EW:0]   ptr_q, end_q;
   logic [RW-1:0] tcnt_q, lvl_q;
   logic [VW:0]   ring_q, cur_q, nxt_q;
   logic          done_q;

   logic          q_push, q_pop, q_empty, q_full, seen;
   logic [VW-1:0] q_din, q_head;
   logic          accept, found;

   assign accept   = (state_q == ST_IDLE) && start;
   assign found    = (state_q == ST_FILT) && !seen;
   assign q_push   = accept || found;
   assign q_din    = accept ? src : col_data;
   assign q_pop    = (state_q == ST_POP) && !q_empty;
   assign busy     = (state_q != ST_IDLE);
   assign done     = done_q;
   assign off_addr = {1'b0, u_q} + ((state_q == ST_ROW_HI) ? (VW+1)'(1) : (VW+1)'(0));
   assign col_addr = ptr_q[EW-1:0];

   bfs_queue #(.VW(VW)) u_queue (
      .clk(clk), .rst_n(rst_n), .push(q_push), .din(q_din), .pop(q_pop),
      .head(q_head), .empty(q_empty), .full(q_full)
   );

   bfs_result_store #(.VW(VW), .RW(RW), .RD_REG(RD_REG)) u_store (
      .clk(clk), .rst_n(rst_n), .clr(accept),
      .disc_we(q_push), .disc_v(q_din),
      .disc_t(accept ? '0 : tcnt_q),
      .disc_lvl(accept ? '0 : lvl_q + 1'b1),
      .disc_par(RW'(accept ? src : u_q)),
      .fin_we(state_q == ST_FIN), .fin_v(u_q), .fin_t(tcnt_q),
      .probe_v(col_data), .probe_seen(seen),
      .rd_addr(rd_addr), .rd_level(rd_level), .rd_parent(rd_parent),
      .rd_disc(rd_disc), .rd_fin(rd_fin)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         u_q     <= '0;
         ptr_q   <= '0;
         end_q   <= '0;
         tcnt_q  <= '0;
         lvl_q   <= '0;
         ring_q  <= '0;
         cur_q   <= '0;
         nxt_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: if (start) begin
               tcnt_q  <= '0;
               lvl_q   <= '0;
               ring_q  <= (VW+1)'(1);
               cur_q   <= '0;
               nxt_q   <= '0;
               state_q <= ST_POP;
            end
            ST_POP: if (q_empty) begin
               done_q  <= 1'b1;
               state_q <= ST_IDLE;
            end else begin
               u_q     <= q_head;
               cur_q   <= cur_q + 1'b1;
               state_q <= ST_ROW_LO;
            end
            ST_ROW_LO:  state_q <= ST_ROW_HI;
            ST_ROW_HI: begin
               ptr_q   <= off_data;
               state_q <= ST_ROW_END;
            end
            ST_ROW_END: begin
               end_q   <= off_data;
               state_q <= ST_SCAN;
            end
            ST_SCAN: if (ptr_q == end_q) begin
               state_q <= ST_FIN;
            end else begin
               ptr_q   <= ptr_q + 1'b1;
               state_q <= ST_FILT;
            end
            ST_FILT: begin
               if (!seen) begin
                  tcnt_q <= tcnt_q + 1'b1;
                  nxt_q  <= nxt_q + 1'b1;
               end
               state_q <= ST_SCAN;
            end
            ST_FIN: begin
               tcnt_q <= tcnt_q + 1'b1;
               if (cur_q == ring_q) begin
                  ring_q <= nxt_q;
                  cur_q  <= '0;
                  nxt_q  <= '0;
                  lvl_q  <= lvl_q + 1'b1;
               end
               state_q <= ST_POP;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R4
   stamp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (tcnt_q == $past(tcnt_q) || tcnt_q == $past(tcnt_q) + 1'b1));

   // R5
   level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && state_q != ST_FIN) |=> $stable(lvl_q));

   // R11
   push_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !q_push) |=> $stable(nxt_q) || $fell(busy) || (cur_q == '0));

   initial begin
      frame_chk: assert (NV >= 2);
   end
endmodule

// File: tb/bfs_engine_tb.sv
module bfs_engine_tb;
   localparam int VW = 4;
   localparam int EW = 6;
   localparam int RW = 6;
   localparam int NV = 1 << VW;
   localparam int NE = 1 << EW;
   localparam int SENT = (1 << RW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [VW-1:0] src = '0;
   logic          busy, done;
   logic [VW:0]   off_addr;
   logic [EW:0]   off_data;
   logic [EW-1:0] col_addr;
   logic [VW-1:0] col_data;
   logic [VW-1:0] rd_addr = '0;
   logic [RW-1:0] rd_level, rd_parent, rd_disc, rd_fin;

   int checks = 0;
   int failures = 0;

   int off_mem [NV+1];
   int col_mem [NE];
   int e_lvl [NV], e_par [NV], e_dsc [NV], e_fin [NV];

   always #2.5 clk = ~clk;

   always_ff @(posedge clk) begin
      off_data <= (EW+1)'(off_mem[off_addr]);
      col_data <= VW'(col_mem[col_addr]);
   end

   bfs_engine #(.VW(VW), .EW(EW), .RW(RW)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .src(src), .busy(busy), .done(done),
      .off_addr(off_addr), .off_data(off_data), .col_addr(col_addr), .col_data(col_data),
      .rd_addr(rd_addr), .rd_level(rd_level), .rd_parent(rd_parent),
      .rd_disc(rd_disc), .rd_fin(rd_fin)
   );

   task automatic check(input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   function automatic int nb(input int kind, input int u, input int k);
      case (kind)
         0: return u + 1;
         1: return 2 * u + 1 + k;
         2: return (k == 0) ? u : (k == 3) ? (u * 5 + 1) % NV : (u + 3) % NV;
         3: return (u < 8) ? (u ^ 1) : 8 + ((u + 1) % 8);
         default: return (u * 11 + k * 13 + 3) % NV;
      endcase
   endfunction

   function automatic int deg(input int kind, input int u);
      case (kind)
         0: return (u < NV - 1) ? 1 : 0;
         1: return (2 * u + 2 < NV) ? 2 : ((2 * u + 1 < NV) ? 1 : 0);
         2: return 4;
         3: return 1;
         default: return (u * 7) % 4;
      endcase
   endfunction

   task automatic build(input int kind);
      int e = 0;
      for (int u = 0; u < NV; u++) begin
         off_mem[u] = e;
         for (int k = 0; k < deg(kind, u); k++) begin
            col_mem[e] = nb(kind, u, k);
            e++;
         end
      end
      off_mem[NV] = e;
   endtask

   task automatic model(input int s);
      int q [NV];
      int hd = 0, tl = 0, tm = 0, ring = 1, cur = 0, nxt = 0, lv = 0, u, v;
      for (int i = 0; i < NV; i++) begin
         e_lvl[i] = SENT; e_par[i] = SENT; e_dsc[i] = SENT; e_fin[i] = SENT;
      end
      e_lvl[s] = 0; e_par[s] = s; e_dsc[s] = 0;
      q[tl] = s; tl++;
      while (hd < tl) begin
         u = q[hd]; hd++;
         cur++;
         for (int e = off_mem[u]; e < off_mem[u+1]; e++) begin
            v = col_mem[e];
            if (e_dsc[v] == SENT) begin
               e_dsc[v] = tm; e_par[v] = u; e_lvl[v] = lv + 1;
               q[tl] = v; tl++;
               tm++; nxt++;
            end
         end
         e_fin[u] = tm; tm++;
         if (cur == ring) begin
            ring = nxt; cur = 0; nxt = 0; lv++;
         end
      end
   endtask

   task automatic run(input int kind, input int s, input bit poke);
      int n = 0;
      string tag;
      tag = (kind == 2) ? "R7" : (kind == 3) ? "R10" : (kind == 1) ? "R11" : "R3";
      model(s);
      @(negedge clk);
      src = VW'(s); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(int'(busy), 1, "R9 busy after start");
      while (!done && n < 4000) begin
         if (poke && n == 10) begin
            src = VW'(s ^ 5); start = 1'b1;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
         n++;
      end
      start = 1'b0;
      check(int'(n < 4000), 1, "R9 done reached");
      @(negedge clk);
      check(int'(done), 0, "R9 done one cycle");
      check(int'(busy), 0, "R9 idle after done");
      for (int i = 0; i < NV; i++) begin
         rd_addr = VW'(i);
         #1;
         check(int'(rd_disc),   e_dsc[i], $sformatf("R4 %s disc g%0d s%0d v%0d", tag, kind, s, i));
         check(int'(rd_fin),    e_fin[i], $sformatf("R4 %s fin g%0d s%0d v%0d", tag, kind, s, i));
         check(int'(rd_level),  e_lvl[i], $sformatf("R5 %s level g%0d s%0d v%0d", tag, kind, s, i));
         check(int'(rd_parent), e_par[i], $sformatf("R6 R8 %s parent g%0d s%0d v%0d", tag, kind, s, i));
      end
      rd_addr = VW'(s);
      #1;
      check(int'(rd_level) + int'(rd_disc), 0, "R2 source level and stamp");
      check(int'(rd_parent), s, "R2 source parent");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(int'(busy), 0, "R1 busy after reset");
      check(int'(done), 0, "R1 done after reset");
      for (int i = 0; i < NV; i++) begin
         rd_addr = VW'(i);
         #1;
         check(int'(rd_level) & int'(rd_parent) & int'(rd_disc) & int'(rd_fin), SENT,
               "R1 sentinel after reset");
      end
      for (int kind = 0; kind < 5; kind++) begin
         build(kind);
         for (int s = 0; s < NV; s++) run(kind, s, 1'b0);
      end
      build(4);
      run(4, 0, 1'b1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(190000 * 5);
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule